// File: doc/BRIEF.md
# Automaton Update Stream Distributor

This block sits between a 64-bit host bus and a bank of pattern-matching engines. Each cycle it may receive one word. Outside an update session, it forwards ordinary words to the matching path. When it sees an opening frame of four consecutive header words, it starts an update session. During the session it turns each update word into a single write, either to the transition table memory or to the final-state flag memory. A closing frame of four consecutive tail words ends the session.

While a session is open, the matching path receives nothing. Idle bus cycles (valid low) do not break a frame count. Any other valid word does break it. Every result is registered, so each result appears exactly one clock after the word that caused it.

An update word has these fields:
- bits [63:41]: a 23-bit marker.
- bit 40: an entry kind.
- bits [39:24]: a 16-bit row (the current state).
- bits [23:16]: an 8-bit column (the input character).
- bits [15:0]: a 16-bit next-state value.

The header and tail patterns are parameters. Their top 23 bits must differ from the marker.

Top module: `upd_stream_distributor`

## Requirements
- R1: After reset, every valid and write-enable output is low, `session_active` is low and `err_count` is zero.
- R2: Outside a session, a valid word that is not the header pattern appears on `match_valid`/`match_word` one cycle later, unchanged.
- R3: Four valid header words in a row open a session; idle cycles between them are allowed. `session_active` rises one cycle after the fourth header word. No header word is ever forwarded.
- R4: A partial header run broken by any other valid word is discarded. That word is forwarded as matching data, and a fresh run of four header words is then needed.
- R5: While `session_active` is high, `match_valid` stays low for every word.
- R6: In a session, a word with the marker and bit 40 = 1 gives `tt_we` one cycle later. It writes `tt_addr` = {bits[39:24], bits[23:16]} (24 bits, row high) and `tt_data` = bits[15:0].
- R7: In a session, a word with the marker and bit 40 = 0 gives `fs_we` one cycle later. It writes `fs_addr` = bits[39:24] and `fs_flag` = bit 0, and bits [23:16] have no effect.
- R8: In a session, a word whose bits [63:41] differ from the marker produces no write. It increments `err_count` one cycle later, and the count saturates at its maximum.
- R9: Four tail words in a row close the session; `session_active` falls one cycle after the fourth. Tail words produce no write and no error. A partial tail run broken by another word is discarded, and that word is decoded as an update word.
- R10: Each accepted word causes at most one write; `tt_we` and `fs_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host word valid |
| in_word | input | 64 | Host word |
| match_valid | output | 1 | Forwarded word valid (matching path) |
| match_word | output | 64 | Forwarded word |
| tt_we | output | 1 | Transition table write enable |
| tt_addr | output | 24 | Transition table address {row, column} |
| tt_data | output | 16 | Next-state value to store |
| fs_we | output | 1 | Final-state memory write enable |
| fs_addr | output | 16 | State whose final flag is written |
| fs_flag | output | 1 | Final flag value |
| session_active | output | 1 | Update session open |
| err_count | output | ERR_W | Saturating count of unmarked words inside sessions |

## Verification
Every result of this block comes one clock edge after the input word that caused it. This covers the forwarded word, both memory writes, the error count step and the session flag edges. The driver applies a word on the falling edge and queues what the outputs must show after the following rising edge. The monitor takes each queued item just after that rising edge and compares every output. So each word is checked against exactly the cycle in which its result is due. Idle cycles are queued as well, so any output that appears early or late shows up as a mismatch.

// File: rtl/upd_pkg.sv
package upd_pkg;
  localparam int WORD_W   = 64;
  localparam int MARK_W   = 23;
  localparam int ROW_W    = 16;
  localparam int COL_W    = 8;
  localparam int NS_W     = 16;
  localparam int TADDR_W  = ROW_W + COL_W;
  localparam int NS_LSB   = 0;
  localparam int COL_LSB  = NS_LSB + NS_W;
  localparam int ROW_LSB  = COL_LSB + COL_W;
  localparam int KIND_BIT = ROW_LSB + ROW_W;
  localparam int MARK_LSB = KIND_BIT + 1;

  typedef enum logic {KIND_FINAL = 1'b0, KIND_TRANS = 1'b1} upd_kind_e;

  function automatic logic [MARK_W-1:0] marker_of(input logic [WORD_W-1:0] w);
    return w[MARK_LSB +: MARK_W];
  endfunction

  function automatic upd_kind_e kind_of(input logic [WORD_W-1:0] w);
    return upd_kind_e'(w[KIND_BIT]);
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [WORD_W-1:0] w);
    return w[ROW_LSB +: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [WORD_W-1:0] w);
    return w[COL_LSB +: COL_W];
  endfunction

  function automatic logic [NS_W-1:0] ns_of(input logic [WORD_W-1:0] w);
    return w[NS_LSB +: NS_W];
  endfunction

  function automatic logic [TADDR_W-1:0] table_addr(input logic [WORD_W-1:0] w);
    return {row_of(w), col_of(w)};
  endfunction
endpackage

// File: rtl/upd_seq_detect.sv
module upd_seq_detect #(
  parameter logic [63:0] PATTERN = 64'h0,
  parameter int          RUN_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        valid,
  input  logic [63:0] word,
  output logic        is_pat,
  output logic        hit
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_cnt;

  assign is_pat = (word == PATTERN);
  assign hit    = enable && valid && is_pat && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      run_cnt <= '0;
    end else if (valid) begin
      if (!is_pat || hit) run_cnt <= '0;
      else                run_cnt <= run_cnt + 1'b1;
    end
  end

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LAST);
endmodule

// File: rtl/upd_word_decode.sv
module upd_word_decode
  import upd_pkg::*;
#(
  parameter logic [MARK_W-1:0] MARK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [WORD_W-1:0]  word,
  output logic               bad_flag,
  output logic               tt_we,
  output logic [TADDR_W-1:0] tt_addr,
  output logic [NS_W-1:0]    tt_data,
  output logic               fs_we,
  output logic [ROW_W-1:0]   fs_addr,
  output logic               fs_flag
);
  logic marked, do_trans, do_final;

  assign marked   = (marker_of(word) == MARK);
  assign bad_flag = take && !marked;
  assign do_trans = take && marked && (kind_of(word) == KIND_TRANS);
  assign do_final = take && marked && (kind_of(word) == KIND_FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tt_we   <= 1'b0;
      fs_we   <= 1'b0;
      tt_addr <= '0;
      tt_data <= '0;
      fs_addr <= '0;
      fs_flag <= 1'b0;
    end else begin
      tt_we <= do_trans;
      fs_we <= do_final;
      if (do_trans) begin
        tt_addr <= table_addr(word);
        tt_data <= ns_of(word);
      end
      if (do_final) begin
        fs_addr <= row_of(word);
        fs_flag <= word[0];
      end
    end
  end

  // R10
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tt_we && fs_we));
  // R8
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_flag |=> !tt_we && !fs_we);
endmodule

// File: rtl/upd_err_count.sv
module upd_err_count #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ERR_W-1:0] count
);
  localparam logic [ERR_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/upd_stream_distributor.sv
module upd_stream_distributor
  import upd_pkg::*;
#(
  parameter logic [63:0]       HDR_WORD  = 64'hFFEE_DDCC_0000_0001,
  parameter logic [63:0]       TAIL_WORD = 64'hFFEE_DDCC_0000_0002,
  parameter logic [MARK_W-1:0] MARK      = 23'h5A5A5A,
  parameter int                FRAME_LEN = 4,
  parameter int                ERR_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [63:0]        in_word,
  output logic               match_valid,
  output logic [63:0]        match_word,
  output logic               tt_we,
  output logic [23:0]        tt_addr,
  output logic [15:0]        tt_data,
  output logic               fs_we,
  output logic [15:0]        fs_addr,
  output logic               fs_flag,
  output logic               session_active,
  output logic [ERR_W-1:0]   err_count
);
  logic session_q;
  logic hdr_is, hdr_hit, tail_is, tail_hit;
  logic fwd, take, bad_flag;
  logic mv_q;
  logic [63:0] mw_q;

  upd_seq_detect #(.PATTERN(HDR_WORD), .RUN_LEN(FRAME_LEN)) hdr_det_i (
    .clk(clk), .rst_n(rst_n), .enable(!session_q), .valid(in_valid),
    .word(in_word), .is_pat(hdr_is), .hit(hdr_hit));

  upd_seq_detect #(.PATTERN(TAIL_WORD), .RUN_LEN(FRAME_LEN)) tail_det_i (
    .clk(clk), .rst_n(rst_n), .enable(session_q), .valid(in_valid),
    .word(in_word), .is_pat(tail_is), .hit(tail_hit));

  assign fwd  = in_valid && !session_q && !hdr_is;
  assign take = in_valid && session_q && !tail_is;

  upd_word_decode #(.MARK(MARK)) dec_i (
    .clk(clk), .rst_n(rst_n), .take(take), .word(in_word),
    .bad_flag(bad_flag), .tt_we(tt_we), .tt_addr(tt_addr), .tt_data(tt_data),
    .fs_we(fs_we), .fs_addr(fs_addr), .fs_flag(fs_flag));

  upd_err_count #(.ERR_W(ERR_W)) err_i (
    .clk(clk), .rst_n(rst_n), .inc(bad_flag), .count(err_count));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      session_q <= 1'b0;
      mv_q      <= 1'b0;
      mw_q      <= '0;
    end else begin
      if (hdr_hit)       session_q <= 1'b1;
      else if (tail_hit) session_q <= 1'b0;
      mv_q <= fwd;
      if (fwd) mw_q <= in_word;
    end
  end

  assign match_valid    = mv_q;
  assign match_word     = mw_q;
  assign session_active = session_q;

  // R5
  no_fwd_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_valid && session_active));
  // R6
  write_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tt_we || fs_we) |-> session_active);
  // R3
  open_by_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_hit |=> session_active && !match_valid);
  // R9
  close_by_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(session_active) |-> $past(tail_hit));
endmodule

// File: tb/upd_stream_distributor_tb.sv
module upd_stream_distributor_tb_top;
  localparam logic [63:0] HDR  = 64'hFFEE_DDCC_0000_0001;
  localparam logic [63:0] TAIL = 64'hFFEE_DDCC_0000_0002;
  localparam logic [22:0] MRK  = 23'h5A5A5A;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [63:0] in_word = '0;
  logic mv, tt_we, fs_we, fs_flag, sess;
  logic [63:0] mw;
  logic [23:0] tt_addr;
  logic [15:0] tt_data, fs_addr;
  logic [7:0]  errc;

  always #2.5 clk = ~clk;

  upd_stream_distributor dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .match_valid(mv), .match_word(mw), .tt_we(tt_we), .tt_addr(tt_addr),
    .tt_data(tt_data), .fs_we(fs_we), .fs_addr(fs_addr), .fs_flag(fs_flag),
    .session_active(sess), .err_count(errc));

  typedef struct {
    logic mv; logic [63:0] mw;
    logic tv; logic [23:0] ta; logic [15:0] td;
    logic fv; logic [15:0] fa; logic ff;
    logic s;  logic [7:0] e;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int hc = 0, tc = 0, m_err = 0;
  bit m_sess = 0;

  function automatic logic [63:0] upd(input logic [22:0] m, input logic k,
    input logic [15:0] row, input logic [7:0] col, input logic [15:0] ns);
    return {m, k, row, col, ns};
  endfunction

  task automatic step(input logic v, input logic [63:0] w, input string tag);
    exp_t x;
    x = '{default: '0};
    if (v) begin
      if (!m_sess) begin
        if (w == HDR) begin
          if (hc == 3) begin hc = 0; m_sess = 1; end else hc++;
        end else begin
          hc = 0; x.mv = 1; x.mw = w;
        end
      end else begin
        if (w == TAIL) begin
          if (tc == 3) begin tc = 0; m_sess = 0; end else tc++;
        end else begin
          tc = 0;
          if (w[63:41] != MRK) begin
            if (m_err < 255) m_err++;
          end else if (w[40]) begin
            x.tv = 1; x.ta = w[39:16]; x.td = w[15:0];
          end else begin
            x.fv = 1; x.fa = w[39:24]; x.ff = w[0];
          end
        end
      end
    end
    x.s = m_sess; x.e = 8'(m_err);
    @(negedge clk);
    in_valid = v; in_word = w;
    q.push_back(x); tq.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t x; string t; bit ok;
        x = q.pop_front(); t = tq.pop_front();
        ok = (mv == x.mv) && (!x.mv || mw == x.mw) && (tt_we == x.tv) &&
             (!x.tv || (tt_addr == x.ta && tt_data == x.td)) && (fs_we == x.fv) &&
             (!x.fv || (fs_addr == x.fa && fs_flag == x.ff)) &&
             (sess == x.s) && (errc == x.e);
        n_cmp++;
        if (!ok) begin
          n_bad++;
          $display("FAIL %s: act mv=%b mw=%h tt=%b/%h/%h fs=%b/%h/%b s=%b e=%0d exp mv=%b mw=%h tt=%b/%h/%h fs=%b/%h/%b s=%b e=%0d",
            t, mv, mw, tt_we, tt_addr, tt_data, fs_we, fs_addr, fs_flag, sess, errc,
            x.mv, x.mw, x.tv, x.ta, x.td, x.fv, x.fa, x.ff, x.s, x.e);
        end
      end
    end
  end

  initial begin : watchdog
    #(5 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    n_cmp++;
    if (mv || tt_we || fs_we || sess || errc != 0) begin
      n_bad++;
      $display("FAIL R1: act mv=%b tt=%b fs=%b s=%b e=%0d exp all zero", mv, tt_we, fs_we, sess, errc);
    end
    // R2 forwarding, with idle gaps
    step(1, 64'h0123_4567_89AB_CDEF, "R2");
    step(0, 64'h0, "R2");
    step(1, 64'hDEAD_BEEF_0000_0042, "R2");
    step(1, upd(MRK, 1, 16'h0005, 8'h41, 16'h0007), "R2");
    // R4 partial header broken
    step(1, HDR, "R4"); step(1, HDR, "R4");
    step(1, 64'h1111_2222_3333_4444, "R4");
    step(1, HDR, "R4"); step(1, HDR, "R4"); step(1, HDR, "R4");
    step(1, 64'h5555_6666_7777_8888, "R4");
    // R3 opening with idle gap
    step(1, HDR, "R3"); step(1, HDR, "R3"); step(0, HDR, "R3");
    step(1, HDR, "R3"); step(1, HDR, "R3");
    // R6 transition writes
    step(1, upd(MRK, 1, 16'h0001, 8'h61, 16'h0002), "R6");
    step(1, upd(MRK, 1, 16'hABCD, 8'hFF, 16'h1234), "R6");
    step(0, 64'h0, "R5");
    step(1, upd(MRK, 1, 16'h0000, 8'h00, 16'hFFFF), "R6");
    // R7 final-state writes, column varied
    step(1, upd(MRK, 0, 16'h0033, 8'h00, 16'h0001), "R7");
    step(1, upd(MRK, 0, 16'h0033, 8'hC7, 16'h0000), "R7");
    step(1, upd(MRK, 0, 16'hFFFE, 8'h5A, 16'hFFFF), "R7");
    // R8 unmarked words, R5 header in session
    step(1, 64'h0123_4567_89AB_CDEF, "R8");
    step(1, HDR, "R5");
    step(1, upd(MRK ^ 23'h1, 1, 16'h0009, 8'h09, 16'h0009), "R8");
    // R9 partial tail then update, then close
    step(1, TAIL, "R9"); step(1, TAIL, "R9");
    step(1, upd(MRK, 1, 16'h0077, 8'h20, 16'h0078), "R9");
    step(1, TAIL, "R9"); step(1, TAIL, "R9"); step(1, TAIL, "R9");
    step(1, TAIL, "R9");
    step(1, 64'h0000_0000_0000_0099, "R2");
    step(1, TAIL, "R2");
    // R8 saturation
    for (int i = 0; i < 4; i++) step(1, HDR, "R3");
    for (int i = 0; i < 260; i++) step(1, 64'(i), "R8");
    step(1, upd(MRK, 1, 16'h0100, 8'h02, 16'h0003), "R10");
    for (int i = 0; i < 4; i++) step(1, TAIL, "R9");
    step(0, 64'h0, "R1");
    repeat (3) @(negedge clk);
    in_valid = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule